// File: doc/BRIEF.md
# Oversampling majority-vote receive path for a serial master

This block decides each incoming bit of a serial-master transfer from many samples instead of one. On every system clock it adds the level of the serial input line to a running count. Once per serial-clock period, on the edge chosen as the shifting edge, it compares that count with a threshold. The threshold comes from the same prescaler setting that spaces the serial-clock edges. The decided bit goes into a receive register, most significant bit first.

A neighbouring serial-clock generator drives the block. That generator gives one strobe for every odd serial-clock edge and one for every even edge. It also gives a start pulse that opens each transfer. An edge-mode input chooses which parity of edge shifts and which parity strobes. A word-length input sets how many bits make up a word, from 1 to 32.

When the last bit of the word has been taken, a done pulse is raised. The word then stays on the output until the next start.

Top module: `spi_rx_vote`

## Requirements
- R1: While reset is held and right after it is released, `rx_word` is 0, `bit_vld` is 0 and `done` is 0.
- R2: A `xfer_start` pulse clears the sample count, the receive word and the bit counter, and arms a new transfer. A shifting edge in the same cycle as `xfer_start` is discarded: in the next cycle `bit_vld` and `done` are 0 and `rx_word` is 0.
- R3: The shifting edge is selected by `edge_mode`. With `edge_mode`=0, even edges (`sck_edge_even`) shift. With `edge_mode`=1, odd edges (`sck_edge_odd`) shift. With `edge_mode`=1, the first odd edge after a start only opens the first sampling window and yields no bit.
- R4: The serial input is sampled on every clock. A window holds the samples from the cycle after the last clear (a start or a shifting edge) up to and including the cycle of the shifting edge that closes it.
- R5: For prescaler value P (legal range 1..15, half period P+1 clocks), the decided bit is 1 only when the window's count of high samples is strictly greater than P+1. A tie decides 0.
- R6: One cycle after a shifting edge that yields a bit, `bit_vld` is 1 and `bit_val` carries the decided bit. `bit_vld` is 0 in every other cycle.
- R7: Each decided bit enters at `rx_word[0]` while earlier bits move up by one. With `word_last`=L, the first bit of the word sits at `rx_word[L]` after the transfer and all bits above L are 0.
- R8: `done` is a one-cycle pulse that comes together with the `bit_vld` of bit number L+1. After that, shifting edges take no bit and `rx_word` holds until the next `xfer_start`.
- R9: In each window of 2(P+1) samples, a glitch that inverts the line for fewer than P+1 clocks does not change the decided bit, in both edge modes.
- R10: The sample count saturates at its maximum (63) and does not wrap when shifting edges stop coming.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously outside |
| xfer_start | input | 1 | One-cycle pulse that opens a transfer |
| sck_edge_odd | input | 1 | Pulse marking an odd serial-clock edge (1st, 3rd, ...) |
| sck_edge_even | input | 1 | Pulse marking an even serial-clock edge (2nd, 4th, ...) |
| edge_mode | input | 1 | 0: even edges shift; 1: odd edges shift |
| presc | input | 4 | Prescaler value P, half serial-clock period is P+1 clocks |
| word_last | input | 5 | Number of bits in the word minus one |
| miso | input | 1 | Raw serial input line |
| bit_vld | output | 1 | One-cycle pulse marking a decided bit |
| bit_val | output | 1 | Decided bit value, valid with bit_vld |
| rx_word | output | 32 | Receive register, first bit received is most significant |
| done | output | 1 | One-cycle pulse when the last bit of the word is taken |

## Verification
Two events can land in the same cycle: a start pulse and the closing shifting edge of a word. The bench forces them together by raising `xfer_start` in the cycle of the final even edge. One cycle later it requires no valid bit, no done pulse and a cleared word, because the start must win.

The other pairing is the accumulator clear and the window's last sample, which happen in the same cycle at every shifting edge. This is judged through the sweep. Inverted-sample runs of P and P+1 clocks sit at the edges of each window, and the expected word flips exactly at the tie.

// File: rtl/svote_pkg.sv
package svote_pkg;

  // Which serial-clock edge parity closes a sampling window.
  typedef enum logic {
    SHIFT_ON_EVEN = 1'b0,
    SHIFT_ON_ODD  = 1'b1
  } shift_sel_e;

  // Width of a counter able to hold every sample of the widest window.
  function automatic int unsigned cnt_width(input int unsigned presc_w);
    return presc_w + 2;
  endfunction

endpackage

// File: rtl/svote_edge_sel.sv
module svote_edge_sel
  import svote_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic xfer_start,
  input  logic edge_odd,
  input  logic edge_even,
  input  logic edge_mode,
  output logic shift_hit,
  output logic take
);

  shift_sel_e sel;
  logic       armed_q;
  logic       armed_d;

  assign sel       = shift_sel_e'(edge_mode);
  assign shift_hit = (sel == SHIFT_ON_ODD) ? edge_odd : edge_even;

  // In odd-shift mode the first shifting edge only opens the first window.
  assign take = shift_hit & ~xfer_start & ((sel == SHIFT_ON_EVEN) | armed_q);

  always_comb begin
    armed_d = armed_q;
    if (xfer_start) begin
      armed_d = 1'b0;
    end else if (shift_hit) begin
      armed_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
    end else begin
      armed_q <= armed_d;
    end
  end

endmodule

// File: rtl/svote_acc.sv
module svote_acc
  import svote_pkg::*;
#(
  parameter int unsigned PW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          miso,
  input  logic [PW-1:0] presc,
  output logic          bit_dec
);

  localparam int unsigned AW = cnt_width(PW);
  localparam logic [AW-1:0] ACC_MAX = {AW{1'b1}};

  logic [AW-1:0] acc_q;
  logic [AW-1:0] acc_d;
  logic [AW:0]   sum;
  logic [AW:0]   thr;

  // The window includes the sample taken in the cycle of the closing edge.
  assign sum     = {1'b0, acc_q} + {{AW{1'b0}}, miso};
  assign thr     = {{(AW + 1 - PW){1'b0}}, presc} + {{AW{1'b0}}, 1'b1};
  assign bit_dec = (sum > thr);

  always_comb begin
    acc_d = acc_q;
    if (clr) begin
      acc_d = '0;
    end else if (miso && (acc_q != ACC_MAX)) begin
      acc_d = acc_q + {{(AW - 1){1'b0}}, 1'b1};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
    end else begin
      acc_q <= acc_d;
    end
  end

endmodule

// File: rtl/svote_shreg.sv
module svote_shreg #(
  parameter int unsigned MAX_BITS = 32,
  parameter int unsigned CW       = $clog2(MAX_BITS)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                xfer_start,
  input  logic                take,
  input  logic                bit_in,
  input  logic [CW-1:0]       word_last,
  output logic [MAX_BITS-1:0] rx_word,
  output logic                bit_vld,
  output logic                bit_val,
  output logic                done
);

  logic [MAX_BITS-1:0] sh_q,  sh_d;
  logic [CW-1:0]       cnt_q, cnt_d;
  logic                act_q, act_d;
  logic                vld_q, vld_d;
  logic                val_q, val_d;
  logic                done_q, done_d;
  logic                accept;

  assign accept = take & act_q;

  always_comb begin
    sh_d   = sh_q;
    cnt_d  = cnt_q;
    act_d  = act_q;
    vld_d  = 1'b0;
    val_d  = val_q;
    done_d = 1'b0;
    if (xfer_start) begin
      sh_d  = '0;
      cnt_d = '0;
      act_d = 1'b1;
    end else if (accept) begin
      sh_d  = {sh_q[MAX_BITS-2:0], bit_in};
      vld_d = 1'b1;
      val_d = bit_in;
      if (cnt_q == word_last) begin
        act_d  = 1'b0;
        done_d = 1'b1;
      end else begin
        cnt_d = cnt_q + {{(CW - 1){1'b0}}, 1'b1};
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '0;
      cnt_q  <= '0;
      act_q  <= 1'b0;
      vld_q  <= 1'b0;
      val_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      sh_q   <= sh_d;
      cnt_q  <= cnt_d;
      act_q  <= act_d;
      vld_q  <= vld_d;
      val_q  <= val_d;
      done_q <= done_d;
    end
  end

  assign rx_word = sh_q;
  assign bit_vld = vld_q;
  assign bit_val = val_q;
  assign done    = done_q;

endmodule

// File: rtl/spi_rx_vote.sv
module spi_rx_vote #(
  parameter int unsigned PW       = 4,
  parameter int unsigned MAX_BITS = 32,
  localparam int unsigned CW      = $clog2(MAX_BITS)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                xfer_start,
  input  logic                sck_edge_odd,
  input  logic                sck_edge_even,
  input  logic                edge_mode,
  input  logic [PW-1:0]       presc,
  input  logic [CW-1:0]       word_last,
  input  logic                miso,
  output logic                bit_vld,
  output logic                bit_val,
  output logic [MAX_BITS-1:0] rx_word,
  output logic                done
);

  logic shift_hit;
  logic take;
  logic bit_dec;
  logic acc_clr;

  assign acc_clr = xfer_start | shift_hit;

  svote_edge_sel u_edge (
    .clk        (clk),
    .rst_n      (rst_n),
    .xfer_start (xfer_start),
    .edge_odd   (sck_edge_odd),
    .edge_even  (sck_edge_even),
    .edge_mode  (edge_mode),
    .shift_hit  (shift_hit),
    .take       (take)
  );

  svote_acc #(.PW(PW)) u_acc (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (acc_clr),
    .miso    (miso),
    .presc   (presc),
    .bit_dec (bit_dec)
  );

  svote_shreg #(.MAX_BITS(MAX_BITS), .CW(CW)) u_shreg (
    .clk        (clk),
    .rst_n      (rst_n),
    .xfer_start (xfer_start),
    .take       (take),
    .bit_in     (bit_dec),
    .word_last  (word_last),
    .rx_word    (rx_word),
    .bit_vld    (bit_vld),
    .bit_val    (bit_val),
    .done       (done)
  );

endmodule

// File: rtl/spi_rx_vote_chk.sv
module spi_rx_vote_chk #(
  parameter int unsigned MAX_BITS = 32
) (
  input logic                clk,
  input logic                rst_n,
  input logic                xfer_start,
  input logic                sck_edge_odd,
  input logic                sck_edge_even,
  input logic                edge_mode,
  input logic                bit_vld,
  input logic                bit_val,
  input logic [MAX_BITS-1:0] rx_word,
  input logic                done
);

  // R6: a valid bit only follows a shifting edge of the selected parity.
  a_r6_vld_after_edge: assert property (@(posedge clk) disable iff (!rst_n)
    bit_vld |-> $past(edge_mode ? sck_edge_odd : sck_edge_even));

  // R6, R7: the reported bit is the one that just entered the word.
  a_r7_val_in_lsb: assert property (@(posedge clk) disable iff (!rst_n)
    bit_vld |-> (rx_word[0] == bit_val));

  // R2: a start leaves a cleared word and no bit or done behind it.
  a_r2_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_start |=> (rx_word == '0) && !bit_vld && !done);

  // R8: done comes only together with a valid bit.
  a_r8_done_with_vld: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> bit_vld);

  // R8: done lasts one cycle.
  a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R7: with no start and no edge, the word does not move.
  a_r7_word_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!xfer_start && !sck_edge_odd && !sck_edge_even) |=> $stable(rx_word));

endmodule

bind spi_rx_vote spi_rx_vote_chk #(.MAX_BITS(MAX_BITS)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .xfer_start    (xfer_start),
  .sck_edge_odd  (sck_edge_odd),
  .sck_edge_even (sck_edge_even),
  .edge_mode     (edge_mode),
  .bit_vld       (bit_vld),
  .bit_val       (bit_val),
  .rx_word       (rx_word),
  .done          (done)
);

// File: tb/spi_rx_vote_tb.sv
module spi_rx_vote_tb;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        xfer_start, sck_edge_odd, sck_edge_even, edge_mode, miso;
  logic [3:0]  presc;
  logic [4:0]  word_last;
  logic        bit_vld, bit_val, done;
  logic [31:0] rx_word;

  int n_chk  = 0;
  int n_fail = 0;
  int cycles = 0;
  logic [31:0] seed = 32'h1234_5678;

  always #2.5 clk = ~clk;

  spi_rx_vote u_dut (
    .clk(clk), .rst_n(rst_n), .xfer_start(xfer_start),
    .sck_edge_odd(sck_edge_odd), .sck_edge_even(sck_edge_even),
    .edge_mode(edge_mode), .presc(presc), .word_last(word_last),
    .miso(miso), .bit_vld(bit_vld), .bit_val(bit_val),
    .rx_word(rx_word), .done(done)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle_inputs();
    xfer_start = 1'b0; sck_edge_odd = 1'b0; sck_edge_even = 1'b0; miso = 1'b0;
  endtask

  // One transfer: edges every H clocks, glitch of g clocks in each window.
  task automatic run_xfer(input int p, input logic md, input int l, input int g,
                          input logic [31:0] wd);
    int h, n_edges, total, vld_err, val_err;
    logic prev_take, prev_bit;
    logic [31:0] exp_word;
    h = p + 1;
    n_edges = md ? 2 * (l + 1) + 1 : 2 * (l + 1);
    total = n_edges * h;
    vld_err = 0; val_err = 0; prev_take = 1'b0; prev_bit = 1'b0;
    exp_word = 0;
    @(negedge clk);
    presc = p[3:0]; edge_mode = md; word_last = l[4:0];
    idle_inputs();
    xfer_start = 1'b1;
    for (int c = 1; c <= total; c++) begin
      int k, off, w, pos, cnt;
      logic b, e, tk;
      @(negedge clk);
      if (bit_vld !== prev_take) vld_err++;
      if (prev_take && (bit_val !== prev_bit)) val_err++;
      idle_inputs();
      k = (c % h == 0) ? c / h : 0;
      if (k != 0) begin
        sck_edge_odd  = k[0];
        sck_edge_even = ~k[0];
      end
      off = md ? h : 0;
      if (c > off) begin
        w = (c - off - 1) / (2 * h);
        pos = (c - off - 1) % (2 * h);
        b = (w <= l) ? wd[l - w] : 1'b0;
        miso = (pos >= 1 && pos < 1 + g) ? ~b : b;
      end else begin
        w = 0; b = 1'b0;
        miso = 1'b0;
      end
      tk = (k != 0) && (md ? (k[0] && k >= 3) : !k[0]);
      if (tk) begin
        cnt = b ? 2 * h - g : g;
        e = (cnt > h);
        exp_word = {exp_word[30:0], e};
        prev_bit = e;
      end
      prev_take = tk;
    end
    @(negedge clk);
    idle_inputs();
    if (bit_vld !== prev_take) vld_err++;
    if (prev_take && (bit_val !== prev_bit)) val_err++;
    check("R6 bit_vld timing", vld_err, 0);
    check("R6 bit_val", val_err, 0);
    check("R8 done with last bit", done, 1);
    check(g >= h ? "R5 tie decides 0" : (g > 0 ? "R9 glitch rejected" : "R7 word"),
          rx_word, exp_word);
  endtask

  initial begin
    int wd_i;
    rst_n = 1'b0;
    idle_inputs();
    edge_mode = 1'b0; presc = 4'd3; word_last = 5'd7;
    repeat (3) @(negedge clk);
    check("R1 reset word", rx_word, 0);
    check("R1 reset vld", bit_vld, 0);
    check("R1 reset done", done, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after release", {bit_vld, done}, 0);

    // Sweep: every prescaler, both edge modes, several lengths and glitches (R3 R4 R5 R9).
    for (int p = 1; p <= 15; p++) begin
      for (int md = 0; md < 2; md++) begin
        for (int li = 0; li < 3; li++) begin
          for (int gi = 0; gi < 3; gi++) begin
            int l, g;
            l = (li == 0) ? 0 : ((li == 1) ? 7 : 31);
            g = (gi == 0) ? 0 : ((gi == 1) ? p : p + 1);
            seed = seed * 32'd1103515245 + 32'd12345;
            run_xfer(p, md[0], l, g, seed);
          end
        end
      end
    end

    // R8: edges after done take nothing and the word holds.
    run_xfer(2, 1'b0, 3, 0, 32'h0000_000B);
    check("R7 MSB first 4-bit", rx_word, 32'h0000_000B);
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      miso = 1'b1;
      sck_edge_odd = i[0]; sck_edge_even = ~i[0];
      @(negedge clk);
      if (bit_vld !== 1'b0) check("R8 no bit after done", bit_vld, 0);
      idle_inputs();
    end
    @(negedge clk);
    check("R8 word held", rx_word, 32'h0000_000B);
    check("R8 no done", done, 0);

    // R2: start in the same cycle as the closing even edge of a 1-bit word.
    @(negedge clk);
    presc = 4'd1; edge_mode = 1'b0; word_last = 5'd0;
    idle_inputs(); xfer_start = 1'b1;
    for (int c = 1; c <= 4; c++) begin
      @(negedge clk);
      idle_inputs(); miso = 1'b1;
      if (c == 2) sck_edge_odd = 1'b1;
      if (c == 4) begin sck_edge_even = 1'b1; xfer_start = 1'b1; end
    end
    @(negedge clk);
    idle_inputs();
    check("R2 start wins vld", bit_vld, 0);
    check("R2 start wins done", done, 0);
    check("R2 start clears word", rx_word, 0);

    // R10: 65 high samples without an edge, then the closing edge.
    @(negedge clk);
    presc = 4'd3; edge_mode = 1'b0; word_last = 5'd0;
    idle_inputs(); xfer_start = 1'b1;
    for (int c = 1; c <= 66; c++) begin
      @(negedge clk);
      idle_inputs(); miso = 1'b1;
      if (c == 66) sck_edge_even = 1'b1;
    end
    @(negedge clk);
    idle_inputs();
    check("R10 saturated count decides 1", {bit_vld, bit_val, done}, 3'b111);
    check("R10 word", rx_word, 1);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 190000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule